// File: doc/BRIEF.md
# FFT Stage Twiddle Angle Generator

This block supplies the rotation angle for one stage of a pipelined radix-r FFT of N points, where N and r are both powers of two. It takes the FFT's free-running control counter and a valid strobe, and turns the counter into an integer angle index in units of 2π/N for a downstream rotator. An index θ stands for a rotation of −(2π/N)·θ. No table and no memory are used. Each angle is built from a few counter bits with a small shift-and-add product and a fixed left shift.

The stage index, the transform size, the radix and the decomposition order (time or frequency) are fixed at elaboration. The decomposition order sets the effective stage e. A time-decimated transform uses e equal to the stage parameter. A frequency-decimated transform uses e = stages + 1 − stage. The angle sequence at effective stage e is r^e long and repeats N/r^e times over one counter period. It is made of r runs of length r^(e−1). Run number p counts 0, p, 2p, and so on.

The result is registered once. It loads only when the strobe is high and otherwise holds its last value. The output valid flag follows the strobe with the same single-cycle delay.

Top module: `twf_angle_gen`

## Requirements
- R1: While reset is asserted and until the first strobed input, valid_o is 0 and angle_o is 0.
- R2: valid_o equals the value valid_i had one clock earlier.
- R3: When valid_i is high, angle_o one clock later equals ((p·k)·N/r^e) mod N, where:
  - p is counter bits [e·log2r−1 : (e−1)·log2r];
  - k is counter bits [(e−1)·log2r−1 : 0].
- R4: The effective stage e is the stage parameter for time decimation and (log_r N) + 1 − stage for frequency decimation.
- R5: At effective stage 1 every angle is 0.
- R6: Counter bits at or above position e·log2r have no effect on angle_o.
- R7: When valid_i is low, angle_o keeps the value it had in the previous cycle.
- R8: The low log2(N/r^e) bits of angle_o are always 0, so every angle lies on the grid of N/r^e steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_i | input | N_LOG2 | FFT control counter value |
| valid_i | input | 1 | Input strobe; counter is sampled when high |
| angle_o | output | N_LOG2 | Angle index θ, rotation −2πθ/N |
| valid_o | output | 1 | Output valid, strobe delayed one cycle |

## Verification
The assertions check on every cycle that:
- the valid flag follows the strobe (R2);
- the angle holds while the strobe is low (R7);
- the angle stays on its stage's grid (R8);
- a first effective stage never produces a nonzero angle (R5).

The actual angle values (R3), the stage reversal for frequency decimation (R4), and the indifference to upper counter bits (R6) are shown only by the bench. The bench runs several stage, radix and order configurations side by side against a division-based reference, using sequential counts, gated strobes and random counter jumps.

// File: rtl/twf_pkg.sv
package twf_pkg;

    typedef enum logic {
        DECIM_TIME = 1'b0,
        DECIM_FREQ = 1'b1
    } decim_e;

    // Effective stage: frequency decimation walks the stages in reverse.
    function automatic int eff_stage(input int n_log2, input int r_log2,
                                     input int stage, input decim_e decim);
        int n_stages;
        n_stages = n_log2 / r_log2;
        return (decim == DECIM_FREQ) ? (n_stages + 1 - stage) : stage;
    endfunction

    function automatic int max1(input int v);
        return (v > 0) ? v : 1;
    endfunction

endpackage

// File: rtl/twf_field_split.sv
// Splits the stage field of the counter into the run digit and the run position.
module twf_field_split #(
    parameter int N_LOG2 = 6,
    parameter int R_LOG2 = 2,
    parameter int EFF    = 2,
    localparam int FIELD_W = EFF * R_LOG2,
    localparam int LOW_W   = (EFF - 1) * R_LOG2,
    localparam int LW      = (LOW_W > 0) ? LOW_W : 1
) (
    input  logic [FIELD_W-1:0] field_i,
    output logic [R_LOG2-1:0]  digit_o,
    output logic [LW-1:0]      pos_o
);

    assign digit_o = field_i[FIELD_W-1 -: R_LOG2];

    generate
        if (LOW_W > 0) begin : g_pos
            assign pos_o = field_i[LW-1:0];
        end else begin : g_no_pos
            assign pos_o = '0;
        end
    endgenerate

endmodule

// File: rtl/twf_digit_mul.sv
// Multiplies a radix digit by the run position using shift-and-add.
module twf_digit_mul #(
    parameter int R_LOG2 = 2,
    parameter int LW     = 2,
    parameter int PW     = 4
) (
    input  logic [R_LOG2-1:0] digit_i,
    input  logic [LW-1:0]     pos_i,
    output logic [PW-1:0]     prod_o
);

    logic [PW-1:0] pos_ext;
    logic [PW-1:0] partial [R_LOG2];

    assign pos_ext = PW'(pos_i);

    generate
        for (genvar j = 0; j < R_LOG2; j++) begin : g_part
            assign partial[j] = digit_i[j] ? (pos_ext << j) : '0;
        end
    endgenerate

    always_comb begin
        prod_o = '0;
        for (int j = 0; j < R_LOG2; j++) begin
            prod_o = prod_o + partial[j];
        end
    end

endmodule

// File: rtl/twf_angle_reg.sv
// Normalises the product to 2*pi/N steps and registers it with the strobe.
module twf_angle_reg #(
    parameter int N_LOG2 = 6,
    parameter int PW     = 4,
    localparam int SHIFT = N_LOG2 - PW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [PW-1:0]     prod_i,
    output logic [N_LOG2-1:0] angle_o,
    output logic              valid_o
);

    logic [N_LOG2-1:0] angle_next;

    assign angle_next = N_LOG2'(prod_i) << SHIFT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            angle_o <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                angle_o <= angle_next;
            end
        end
    end

endmodule

// File: rtl/twf_angle_gen.sv
module twf_angle_gen
    import twf_pkg::*;
#(
    parameter int     N_LOG2 = 6,
    parameter int     R_LOG2 = 2,
    parameter int     STAGE  = 2,
    parameter decim_e DECIM  = DECIM_TIME
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_LOG2-1:0] cnt_i,
    input  logic              valid_i,
    output logic [N_LOG2-1:0] angle_o,
    output logic              valid_o
);

    localparam int EFF     = eff_stage(N_LOG2, R_LOG2, STAGE, DECIM);
    localparam int FIELD_W = EFF * R_LOG2;
    localparam int LW      = max1((EFF - 1) * R_LOG2);

    logic [R_LOG2-1:0]  digit;
    logic [LW-1:0]      pos;
    logic [FIELD_W-1:0] prod;

    generate
        if (FIELD_W < N_LOG2) begin : g_hi
            logic unused_hi_bits;
            assign unused_hi_bits = ^cnt_i[N_LOG2-1:FIELD_W];
        end
    endgenerate

    twf_field_split #(
        .N_LOG2 (N_LOG2),
        .R_LOG2 (R_LOG2),
        .EFF    (EFF)
    ) u_split (
        .field_i (cnt_i[FIELD_W-1:0]),
        .digit_o (digit),
        .pos_o   (pos)
    );

    twf_digit_mul #(
        .R_LOG2 (R_LOG2),
        .LW     (LW),
        .PW     (FIELD_W)
    ) u_mul (
        .digit_i (digit),
        .pos_i   (pos),
        .prod_o  (prod)
    );

    twf_angle_reg #(
        .N_LOG2 (N_LOG2),
        .PW     (FIELD_W)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (valid_i),
        .prod_i  (prod),
        .angle_o (angle_o),
        .valid_o (valid_o)
    );

endmodule

// File: rtl/twf_angle_chk.sv
module twf_angle_chk
    import twf_pkg::*;
#(
    parameter int     N_LOG2 = 6,
    parameter int     R_LOG2 = 2,
    parameter int     STAGE  = 2,
    parameter decim_e DECIM  = DECIM_TIME
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic [N_LOG2-1:0] angle_o,
    input logic              valid_o
);

    localparam int EFF   = eff_stage(N_LOG2, R_LOG2, STAGE, DECIM);
    localparam int SHIFT = N_LOG2 - EFF * R_LOG2;

    p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);

    p_valid_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !valid_o);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(angle_o));

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (angle_o == '0));

    generate
        if (SHIFT > 0) begin : g_grid
            p_grid_r8: assert property (@(posedge clk) disable iff (!rst_n)
                valid_o |-> (angle_o[SHIFT-1:0] == '0));
        end
        if (EFF == 1) begin : g_first
            p_first_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
                angle_o == '0);
        end
    endgenerate

endmodule

bind twf_angle_gen twf_angle_chk #(
    .N_LOG2 (N_LOG2),
    .R_LOG2 (R_LOG2),
    .STAGE  (STAGE),
    .DECIM  (DECIM)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_i),
    .angle_o (angle_o),
    .valid_o (valid_o)
);

// File: tb/twf_angle_gen_tb.sv
`timescale 1ns/1ps
module twf_angle_gen_tb;
    import twf_pkg::*;

    localparam int NL   = 6;
    localparam int N    = 1 << NL;
    localparam int NCFG = 14;

    function automatic int cfg_rl(input int k);
        if (k < 6)  return 1;
        if (k < 12) return 2;
        return 1;
    endfunction

    function automatic int cfg_st(input int k);
        if (k < 6)   return k + 1;
        if (k < 9)   return k - 5;
        if (k < 12)  return k - 8;
        if (k == 12) return 2;
        return 5;
    endfunction

    function automatic decim_e cfg_dc(input int k);
        return (k >= 9) ? DECIM_FREQ : DECIM_TIME;
    endfunction

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NL-1:0] cnt = '0;
    logic vin = 1'b0;
    logic [NL-1:0] ang_w [NCFG];
    logic          val_w [NCFG];

    always #4 clk = ~clk;

    generate
        for (genvar k = 0; k < NCFG; k++) begin : g_cfg
            twf_angle_gen #(
                .N_LOG2 (NL),
                .R_LOG2 (cfg_rl(k)),
                .STAGE  (cfg_st(k)),
                .DECIM  (cfg_dc(k))
            ) u_dut (
                .clk     (clk),
                .rst_n   (rst_n),
                .cnt_i   (cnt),
                .valid_i (vin),
                .angle_o (ang_w[k]),
                .valid_o (val_w[k])
            );
        end
    endgenerate

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;
    int exp_ang [NCFG];
    bit exp_val;

    // Behavioural model: position within the repeating sequence, run index, offset.
    function automatic int ref_angle(input int k, input int c);
        int r, nst, e, len, sub, p, off;
        r   = 1 << cfg_rl(k);
        nst = NL / cfg_rl(k);
        e   = (cfg_dc(k) == DECIM_FREQ) ? nst + 1 - cfg_st(k) : cfg_st(k);
        len = r ** e;
        sub = len / r;
        p   = (c % len) / sub;
        off = (c % len) % sub;
        return (p * off * (N / len)) % N;
    endfunction

    function automatic int eff_of(input int k);
        int nst;
        nst = NL / cfg_rl(k);
        return (cfg_dc(k) == DECIM_FREQ) ? nst + 1 - cfg_st(k) : cfg_st(k);
    endfunction

    task automatic compare(input string tag);
        string req;
        for (int k = 0; k < NCFG; k++) begin
            vectors++;
            if (val_w[k] !== exp_val) begin
                fails++;
                $display("FAIL R2 cfg%0d valid actual %b expected %b", k, val_w[k], exp_val);
            end
            req = (eff_of(k) == 1) ? "R5" : (cfg_dc(k) == DECIM_FREQ) ? "R4" : tag;
            if (ang_w[k] !== NL'(exp_ang[k])) begin
                fails++;
                $display("FAIL %s cfg%0d angle actual %0d expected %0d", req, k, ang_w[k], exp_ang[k]);
            end
        end
    endtask

    task automatic step(input logic v, input logic [NL-1:0] c, input string tag);
        @(negedge clk);
        compare(tag);
        vin = v;
        cnt = c;
        exp_val = v;
        if (v) begin
            for (int k = 0; k < NCFG; k++) exp_ang[k] = ref_angle(k, int'(c));
        end
    endtask

    initial begin
        exp_val = 0;
        for (int k = 0; k < NCFG; k++) exp_ang[k] = 0;
        repeat (3) @(negedge clk);
        compare("R1");                       // R1: outputs cleared in reset
        rst_n = 1'b1;
        step(1'b0, '0, "R1");
        // R3: two full counter periods, strobe always high
        for (int i = 0; i < 2 * N; i++) step(1'b1, NL'(i), "R3");
        // R7: strobe gated, angle must hold
        for (int i = 0; i < N; i++) step(i % 3 != 2, NL'(i * 5 + 1), "R7");
        // R6: arbitrary counter jumps incl. upper bits
        for (int i = 0; i < 3 * N; i++) step(1'b1, NL'($urandom), "R6");
        step(1'b0, '0, "R7");
        step(1'b0, '1, "R7");
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule